// File: doc/BRIEF.md
# Operate Instruction Execute Unit

This block carries out the three operate instructions of a 16-bit load/store machine: addition, bitwise AND and bitwise complement. Each cycle it takes one 16-bit instruction word, splits out the register indices, and asks an external eight-entry register file for two source values through a pair of combinational read ports. It forms the second operand either from the second read port or from a small signed constant carried in the instruction. It computes the result and presents result, destination index and write enable from registers one clock later.

Flag updates, memory traffic and the register storage live elsewhere. The write enable is the only indication that the instruction word held one of the three supported operations. Any other opcode passes through as a no-write cycle, so the unit can sit in a wider execute path without extra qualification.

Top module: `opx_exec_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after, wr_en, result and dest_idx read zero.
- R2: Opcode 4'b0001 in instr[15:12] adds the two operands; the 16-bit result wraps modulo 2^16, with no carry or overflow output, and appears one clock after the instruction is presented.
- R3: Opcode 4'b0101 in instr[15:12] yields the bitwise AND of the two operands one clock later.
- R4: Opcode 4'b1001 in instr[15:12] yields the bitwise complement of the first source value one clock later. instr[5:0] and the second read port have no effect, and source and destination may name the same register.
- R5: src1_idx equals instr[8:6] in the same cycle, and dest_idx equals the instr[11:9] that was presented one clock earlier.
- R6: With instr[5] = 0, the second operand is the value returned for src2_idx, where src2_idx = instr[2:0]. instr[4:3] have no effect.
- R7: With instr[5] = 1 under ADD or AND, the second operand is instr[4:0] sign-extended to 16 bits (range -16..+15). The second read port has no effect.
- R8: Any opcode other than 0001, 0101 or 1001 gives wr_en = 0 one clock later.
- R9: Each of the three supported opcodes gives wr_en = 1 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 16 | Instruction word for this cycle |
| src1_idx | output | 3 | Register-file index for the first source |
| src2_idx | output | 3 | Register-file index for the second source |
| src1_data | input | 16 | Value read at src1_idx, same cycle |
| src2_data | input | 16 | Value read at src2_idx, same cycle |
| result | output | 16 | Registered operation result |
| dest_idx | output | 3 | Registered destination register index |
| wr_en | output | 1 | Registered write enable for the destination |

## Verification
The properties assume that src1_data and src2_data answer the indices the unit drives in the same cycle, combinationally and without holes. They also assume that instr is stable around each rising edge. The bench meets this by modelling the register file as an array indexed directly by the unit's index outputs, and by changing instr and the array contents only on falling edges. Random instruction words cover every opcode value, both operand modes and arbitrary filler bits. Directed words target the immediate extremes, the wrap at 0x7FFF/0xFFFF and a complement whose destination equals its source.

// File: rtl/opx_pkg.sv
package opx_pkg;
  localparam int WORD_W    = 16;
  localparam int IDX_W     = 3;
  localparam int IMM_W     = 5;
  localparam int OPC_W     = 4;
  localparam int OPC_LSB   = WORD_W - OPC_W;
  localparam int DST_LSB   = OPC_LSB - IDX_W;
  localparam int SRC1_LSB  = DST_LSB - IDX_W;
  localparam int MODE_BIT  = SRC1_LSB - 1;
  localparam int SRC2_LSB  = 0;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_ADD  = 2'd1,
    K_AND  = 2'd2,
    K_NOT  = 2'd3
  } op_kind_e;

  function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] imm);
    return {{(WORD_W-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  function automatic logic [WORD_W-1:0] alu_eval(input op_kind_e k,
                                                 input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    logic [WORD_W-1:0] r;
    case (k)
      K_ADD:   r = a + b;
      K_AND:   r = a & b;
      K_NOT:   r = ~a;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/opx_decode.sv
module opx_decode
  import opx_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output op_kind_e          kind,
  output logic [IDX_W-1:0]  dst,
  output logic [IDX_W-1:0]  src1,
  output logic [IDX_W-1:0]  src2,
  output logic              imm_sel,
  output logic [IMM_W-1:0]  imm
);
  logic [OPC_W-1:0] opc;
  assign opc  = instr[OPC_LSB +: OPC_W];
  assign dst  = instr[DST_LSB +: IDX_W];
  assign src1 = instr[SRC1_LSB +: IDX_W];
  assign src2 = instr[SRC2_LSB +: IDX_W];
  assign imm  = instr[IMM_W-1:0];

  always_comb begin
    case (opc)
      OPC_ADD: kind = K_ADD;
      OPC_AND: kind = K_AND;
      OPC_NOT: kind = K_NOT;
      default: kind = K_NONE;
    endcase
  end

  // complement has no second operand, so mode only matters for ADD/AND
  assign imm_sel = instr[MODE_BIT] && (kind == K_ADD || kind == K_AND);
endmodule

// File: rtl/opx_operand.sv
module opx_operand
  import opx_pkg::*;
(
  input  logic              imm_sel,
  input  logic [IMM_W-1:0]  imm,
  input  logic [WORD_W-1:0] reg_val,
  output logic [WORD_W-1:0] operand_b
);
  assign operand_b = imm_sel ? sext_imm(imm) : reg_val;
endmodule

// File: rtl/opx_alu.sv
module opx_alu
  import opx_pkg::*;
(
  input  op_kind_e          kind,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] res,
  output logic              legal
);
  assign res   = alu_eval(kind, a, b);
  assign legal = (kind != K_NONE);
endmodule

// File: rtl/opx_exec_unit.sv
module opx_exec_unit
  import opx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] instr,
  output logic [IDX_W-1:0]  src1_idx,
  output logic [IDX_W-1:0]  src2_idx,
  input  logic [WORD_W-1:0] src1_data,
  input  logic [WORD_W-1:0] src2_data,
  output logic [WORD_W-1:0] result,
  output logic [IDX_W-1:0]  dest_idx,
  output logic              wr_en
);
  op_kind_e          kind;
  logic [IDX_W-1:0]  dst;
  logic              imm_sel;
  logic [IMM_W-1:0]  imm;
  logic [WORD_W-1:0] operand_b;
  logic [WORD_W-1:0] alu_res;
  logic              alu_legal;

  opx_decode u_dec (
    .instr   (instr),
    .kind    (kind),
    .dst     (dst),
    .src1    (src1_idx),
    .src2    (src2_idx),
    .imm_sel (imm_sel),
    .imm     (imm)
  );

  opx_operand u_opb (
    .imm_sel   (imm_sel),
    .imm       (imm),
    .reg_val   (src2_data),
    .operand_b (operand_b)
  );

  opx_alu u_alu (
    .kind  (kind),
    .a     (src1_data),
    .b     (operand_b),
    .res   (alu_res),
    .legal (alu_legal)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      dest_idx <= '0;
      wr_en    <= 1'b0;
    end else begin
      result   <= alu_res;
      dest_idx <= dst;
      wr_en    <= alu_legal;
    end
  end
endmodule

// File: rtl/opx_exec_unit_chk.sv
module opx_exec_unit_chk
  import opx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] instr,
  input logic [IDX_W-1:0]  src1_idx,
  input logic [WORD_W-1:0] src1_data,
  input logic [WORD_W-1:0] src2_data,
  input logic [WORD_W-1:0] operand_b,
  input logic [WORD_W-1:0] result,
  input logic [IDX_W-1:0]  dest_idx,
  input logic              wr_en
);
  logic [OPC_W-1:0] opc;
  assign opc = instr[OPC_LSB +: OPC_W];

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (!wr_en && result == '0));

  a_r5_src1_index: assert property (@(posedge clk) disable iff (!rst_n)
    src1_idx == instr[SRC1_LSB +: IDX_W]);

  a_r5_dest_index: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dest_idx == $past(instr[DST_LSB +: IDX_W]));

  a_r2_add_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_ADD && !instr[MODE_BIT]) |=>
      (result - $past(src1_data)) == $past(src2_data));

  a_r3_and_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_AND && !instr[MODE_BIT]) |=>
      ((result & ~$past(src1_data)) == '0 && (result & ~$past(src2_data)) == '0));

  a_r4_not_complement: assert property (@(posedge clk) disable iff (!rst_n)
    opc == OPC_NOT |=> (result ^ $past(src1_data)) == '1);

  a_r6_reg_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_AND && !instr[MODE_BIT]) |-> operand_b == src2_data);

  a_r7_imm_positive_and: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_AND && instr[MODE_BIT] && !instr[IMM_W-1]) |=>
      result[WORD_W-1:IMM_W-1] == '0);

  a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (opc != OPC_ADD && opc != OPC_AND && opc != OPC_NOT) |=> !wr_en);

  a_r9_write: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_ADD || opc == OPC_AND || opc == OPC_NOT) |=> wr_en);
endmodule

bind opx_exec_unit opx_exec_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .instr     (instr),
  .src1_idx  (src1_idx),
  .src1_data (src1_data),
  .src2_data (src2_data),
  .operand_b (operand_b),
  .result    (result),
  .dest_idx  (dest_idx),
  .wr_en     (wr_en)
);

// File: tb/opx_exec_unit_tb.sv
`timescale 1ns/1ps
module opx_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [2:0]  src1_idx, src2_idx, dest_idx;
  logic [15:0] src1_data, src2_data, result;
  logic        wr_en;
  logic [15:0] regs [8];
  int          checks = 0;
  int          failures = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  assign src1_data = regs[src1_idx];
  assign src2_data = regs[src2_idx];

  opx_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr(instr),
    .src1_idx(src1_idx), .src2_idx(src2_idx),
    .src1_data(src1_data), .src2_data(src2_data),
    .result(result), .dest_idx(dest_idx), .wr_en(wr_en)
  );

  function automatic logic [15:0] second_val(input logic [15:0] ins);
    int v;
    if (ins[5]) begin
      v = int'(ins[4:0]);
      if (ins[4]) v = v - 32;
      return 16'(v);
    end
    return regs[ins[2:0]];
  endfunction

  function automatic bit is_op(input logic [15:0] ins);
    return ins[15:12] inside {4'h1, 4'h5, 4'h9};
  endfunction

  function automatic logic [15:0] model(input logic [15:0] ins);
    logic [15:0] a = regs[ins[8:6]];
    logic [15:0] b = second_val(ins);
    casez (ins[15:12])
      4'h1:    return 16'((32'(a) + 32'(b)) % 32'h10000);
      4'h5:    return a & b;
      4'h9:    return a ^ 16'hFFFF;
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [15:0] ins);
    logic [15:0] exp_res;
    bit          exp_we;
    @(negedge clk);
    instr = ins;
    #1;
    check({tag, " R5 src1_idx"}, 16'(src1_idx), 16'(ins[8:6]));
    exp_res = model(ins);
    exp_we  = is_op(ins);
    @(negedge clk);
    check({tag, exp_we ? " R9 wr_en" : " R8 wr_en"}, 16'(wr_en), 16'(exp_we));
    if (exp_we) begin
      check({tag, " result"}, result, exp_res);
      check({tag, " R5 dest_idx"}, 16'(dest_idx), 16'(ins[11:9]));
    end
  endtask

  function automatic logic [15:0] mk(input logic [3:0] op, input logic [2:0] d,
                                     input logic [2:0] s1, input logic [5:0] low);
    return {op, d, s1, low};
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 16'(i * 16'h1111);
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset wr_en", 16'(wr_en), 16'h0);
    check("R1 reset result", result, 16'h0);
    check("R1 reset dest_idx", 16'(dest_idx), 16'h0);
    rst_n = 1'b1;
    check("R1 post-reset wr_en", 16'(wr_en), 16'h0);

    regs[1] = 16'h7FFF; regs[2] = 16'h0001; regs[3] = 16'hFFFF; regs[4] = 16'hA5C3;
    run_op("R2 add 7FFF+1", mk(4'h1, 3'd0, 3'd1, 6'b000_010));
    run_op("R2 add FFFF+1 wraps", mk(4'h1, 3'd5, 3'd3, 6'b000_010));
    run_op("R7 add imm -16", mk(4'h1, 3'd6, 3'd2, 6'b110_000));
    run_op("R7 add imm +15", mk(4'h1, 3'd7, 3'd3, 6'b101_111));
    run_op("R3 and reg", mk(4'h5, 3'd1, 3'd4, 6'b000_011));
    run_op("R7 and imm -1", mk(4'h5, 3'd2, 3'd4, 6'b111_111));
    run_op("R6 and reg bits43 set", mk(4'h5, 3'd2, 3'd4, 6'b011_011));
    run_op("R4 not same reg", mk(4'h9, 3'd4, 3'd4, 6'b111_111));
    run_op("R4 not low bits ignored", mk(4'h9, 3'd0, 3'd4, 6'b000_000));
    run_op("R8 opcode 0000", mk(4'h0, 3'd1, 3'd1, 6'b000_001));
    run_op("R8 opcode 1111", mk(4'hF, 3'd3, 3'd2, 6'b100_000));
    run_op("R8 opcode 0010", mk(4'h2, 3'd7, 3'd7, 6'b000_000));

    for (int n = 0; n < 400; n++) begin
      logic [15:0] w;
      if (n % 16 == 0)
        for (int i = 0; i < 8; i++) regs[i] = 16'($urandom);
      w = 16'($urandom);
      if (n % 2 == 0) begin
        case ($urandom % 3)
          0: w[15:12] = 4'h1;
          1: w[15:12] = 4'h5;
          default: w[15:12] = 4'h9;
        endcase
      end
      run_op("R6 R7 random", w);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule